// File: doc/BRIEF.md
# Completion Queue Producer

This block sits on the device side of a completion queue that lives in host memory. Software sets it up through a small register write port. It programs where the ring starts, how many slots it has, where in host memory the device should mirror its producer index, and the consumer index that software has reached. Finished work results arrive on a valid/ready stream. Each result carries a request identifier, a byte count, a status code and a 64-bit metadata word.

For every accepted result the block does three things in order:
1. It writes a 16-byte completion record into the slot at its producer index.
2. It waits for that write to be acknowledged.
3. It writes the advanced producer index to the mirror address. After that write is acknowledged, it pulses an interrupt line.

Both indices wrap modulo the ring size. One slot is always kept empty, so a full ring can be told apart from an empty one. When the ring is full the result stream is held off until software writes a new consumer index.

Back-pressure rules:
- A result is taken on a cycle where `res_valid` and `res_ready` are both high.
- `res_ready` is low while a record/index pass is in flight, while the ring is full, and while the ring size is below two.
- On the memory side, a request holds its address and data steady until `mw_ready` is seen.
- Completion of a write is signalled later by a one-cycle `mw_done`.

Top module: `cq_producer`

## Requirements
- R1: After reset the producer and consumer indices are zero, the ring size is zero, `mw_valid` and `irq_pulse` are low, and `res_ready` stays low while the ring size is below two.
- R2: A configuration write with `cfg_sel` 0 loads the ring base address, 1 loads the ring size in slots and clears both indices, 2 loads the mirror address, and 3 loads the consumer index from the low index bits of `cfg_wdata`.
- R3: The first memory write for a result goes to base + producer index × 16. Its 128-bit data holds the identifier in bits [15:0], the length in bits [47:16], the status in bits [63:48] and the metadata in bits [127:64].
- R4: The second memory write goes to the mirror address. Its data is the advanced producer index, zero-extended to 128 bits. It is requested only after `mw_done` for the record write has been seen.
- R5: The producer index advances by one per result and wraps from size−1 back to zero.
- R6: The ring is full when (producer index + 1) mod size equals the consumer index. While it is full, `res_ready` is low and no memory write is issued, however long `res_valid` is held.
- R7: Writing a consumer index that frees slots makes `res_ready` rise again, and stream acceptance resumes.
- R8: `irq_pulse` is high for exactly one cycle, the cycle after `mw_done` for the index write, and at no other time.
- R9: While `mw_valid` is high and `mw_ready` is low, `mw_valid`, `mw_addr` and `mw_data` hold steady. At most one result is in flight, so `res_ready` is low whenever a pass is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select (0 base, 1 size, 2 mirror address, 3 consumer index) |
| cfg_wdata | input | ADDR_W | Configuration write data |
| res_valid | input | 1 | Result stream valid |
| res_ready | output | 1 | Result stream ready |
| res_id | input | 16 | Request identifier |
| res_len | input | 32 | Valid data length in bytes |
| res_sts | input | 16 | Status code |
| res_meta | input | 64 | Device metadata |
| mw_valid | output | 1 | Memory write request valid |
| mw_ready | input | 1 | Memory write request accepted |
| mw_addr | output | ADDR_W | Memory write byte address |
| mw_data | output | 128 | Memory write data beat |
| mw_done | input | 1 | One-cycle write-complete acknowledge, arriving at least one cycle after acceptance |
| irq_pulse | output | 1 | Interrupt pulse after the index is published |

## Verification
The bench targets the following corner cases.

- **Ordering.** The memory model counts any new write request made before the previous one was acknowledged. A design that published the index early would be caught that way.
- **Slot address and packing.** A swapped field or a wrong slot stride shows up as a data or address mismatch against the scoreboard.
- **Wrap.** The ring is filled until it is full, and the bench checks that `res_ready` drops with a valid result held. Slots are then freed so the index wraps. A design using the plain "indices equal" test for full, or one that fails to wrap, would publish the wrong index or accept into an occupied slot.
- **Re-initialisation.** Rewriting the ring size must restart at slot zero.
- **Interrupt timing.** The interrupt is checked cycle by cycle against the acknowledge of the index write. A pulse tied to the record write would be reported.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int ID_W   = 16;
  localparam int LEN_W  = 32;
  localparam int STS_W  = 16;
  localparam int META_W = 64;
  localparam int BEAT_W = ID_W + LEN_W + STS_W + META_W;
  localparam int REC_BYTES  = BEAT_W / 8;
  localparam int SLOT_SHIFT = $clog2(REC_BYTES);

  localparam logic [1:0] SEL_BASE   = 2'd0;
  localparam logic [1:0] SEL_SIZE   = 2'd1;
  localparam logic [1:0] SEL_MIRROR = 2'd2;
  localparam logic [1:0] SEL_CONS   = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REC_REQ,
    ST_REC_WAIT,
    ST_IDX_REQ,
    ST_IDX_WAIT
  } cq_state_e;

  function automatic logic [BEAT_W-1:0] pack_record(
    input logic [ID_W-1:0]   id,
    input logic [LEN_W-1:0]  len,
    input logic [STS_W-1:0]  sts,
    input logic [META_W-1:0] meta
  );
    return {meta, sts, len, id};
  endfunction
endpackage

// File: rtl/cq_cfg_regs.sv
module cq_cfg_regs
  import cq_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] ring_base,
  output logic [ADDR_W-1:0] mirror_addr,
  output logic [IDX_W-1:0]  ring_size,
  output logic [IDX_W-1:0]  cons_idx,
  output logic              ring_init
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_base   <= '0;
      mirror_addr <= '0;
      ring_size   <= '0;
      cons_idx    <= '0;
    end else if (cfg_we) begin
      unique case (cfg_sel)
        SEL_BASE:   ring_base   <= cfg_wdata;
        SEL_SIZE: begin
          ring_size <= cfg_wdata[IDX_W-1:0];
          cons_idx  <= '0;
        end
        SEL_MIRROR: mirror_addr <= cfg_wdata;
        default:    cons_idx    <= cfg_wdata[IDX_W-1:0];
      endcase
    end
  end

  assign ring_init = cfg_we && (cfg_sel == SEL_SIZE);
endmodule

// File: rtl/cq_ring_ptr.sv
module cq_ring_ptr #(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring_init,
  input  logic             advance,
  input  logic [IDX_W-1:0] ring_size,
  input  logic [IDX_W-1:0] cons_idx,
  output logic [IDX_W-1:0] prod_idx,
  output logic [IDX_W-1:0] prod_next,
  output logic             ring_full
);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);
  localparam logic [IDX_W-1:0] TWO = IDX_W'(2);

  logic at_last;
  logic too_small;

  assign at_last   = (prod_idx == ring_size - ONE);
  assign too_small = (ring_size < TWO);
  assign prod_next = (too_small || at_last) ? '0 : prod_idx + ONE;
  assign ring_full = too_small || (prod_next == cons_idx);

  always_ff @(posedge clk) begin
    if (!rst_n || ring_init) begin
      prod_idx <= '0;
    end else if (advance) begin
      prod_idx <= prod_next;
    end
  end
endmodule

// File: rtl/cq_seq.sv
module cq_seq
  import cq_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [ID_W-1:0]   res_id,
  input  logic [LEN_W-1:0]  res_len,
  input  logic [STS_W-1:0]  res_sts,
  input  logic [META_W-1:0] res_meta,
  input  logic              ring_full,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [ADDR_W-1:0] mirror_addr,
  input  logic [IDX_W-1:0]  prod_idx,
  input  logic [IDX_W-1:0]  prod_next,
  output logic              advance,
  output logic              mw_valid,
  input  logic              mw_ready,
  output logic [ADDR_W-1:0] mw_addr,
  output logic [BEAT_W-1:0] mw_data,
  input  logic              mw_done,
  output logic              irq_pulse
);
  cq_state_e state;
  logic [ADDR_W-1:0] slot_addr;
  logic              take;

  assign slot_addr = ring_base + (ADDR_W'(prod_idx) << SLOT_SHIFT);
  assign res_ready = (state == ST_IDLE) && !ring_full;
  assign take      = res_valid && res_ready;
  assign mw_valid  = (state == ST_REC_REQ) || (state == ST_IDX_REQ);
  assign advance   = (state == ST_REC_WAIT) && mw_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      mw_addr   <= '0;
      mw_data   <= '0;
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= 1'b0;
      unique case (state)
        ST_IDLE: if (take) begin
          mw_addr <= slot_addr;
          mw_data <= pack_record(res_id, res_len, res_sts, res_meta);
          state   <= ST_REC_REQ;
        end
        ST_REC_REQ:  if (mw_ready) state <= ST_REC_WAIT;
        ST_REC_WAIT: if (mw_done) begin
          mw_addr <= mirror_addr;
          mw_data <= {{(BEAT_W-IDX_W){1'b0}}, prod_next};
          state   <= ST_IDX_REQ;
        end
        ST_IDX_REQ:  if (mw_ready) state <= ST_IDX_WAIT;
        ST_IDX_WAIT: if (mw_done) begin
          irq_pulse <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cq_producer.sv
module cq_producer
  import cq_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [15:0]       res_id,
  input  logic [31:0]       res_len,
  input  logic [15:0]       res_sts,
  input  logic [63:0]       res_meta,
  output logic              mw_valid,
  input  logic              mw_ready,
  output logic [ADDR_W-1:0] mw_addr,
  output logic [127:0]      mw_data,
  input  logic              mw_done,
  output logic              irq_pulse
);
  logic [ADDR_W-1:0] ring_base;
  logic [ADDR_W-1:0] mirror_addr;
  logic [IDX_W-1:0]  ring_size;
  logic [IDX_W-1:0]  cons_idx;
  logic [IDX_W-1:0]  prod_idx;
  logic [IDX_W-1:0]  prod_next;
  logic              ring_init;
  logic              ring_full;
  logic              advance;

  cq_cfg_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ring_base(ring_base), .mirror_addr(mirror_addr),
    .ring_size(ring_size), .cons_idx(cons_idx), .ring_init(ring_init)
  );

  cq_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ring_init(ring_init), .advance(advance),
    .ring_size(ring_size), .cons_idx(cons_idx), .prod_idx(prod_idx),
    .prod_next(prod_next), .ring_full(ring_full)
  );

  cq_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_id(res_id), .res_len(res_len), .res_sts(res_sts), .res_meta(res_meta),
    .ring_full(ring_full), .ring_base(ring_base), .mirror_addr(mirror_addr),
    .prod_idx(prod_idx), .prod_next(prod_next), .advance(advance),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr),
    .mw_data(mw_data), .mw_done(mw_done), .irq_pulse(irq_pulse)
  );
endmodule

// File: rtl/cq_producer_chk.sv
module cq_producer_chk #(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic              res_ready,
  input logic              mw_valid,
  input logic              mw_ready,
  input logic [ADDR_W-1:0] mw_addr,
  input logic [127:0]      mw_data,
  input logic              mw_done,
  input logic              irq_pulse,
  input logic              ring_full,
  input logic [IDX_W-1:0]  prod_idx,
  input logic [IDX_W-1:0]  ring_size
);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data));

  assert_one_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid |-> !res_ready);

  assert_no_accept_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ring_full |-> !res_ready);

  assert_irq_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(mw_done));

  assert_accept_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> mw_valid);

  assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_size != '0) |-> (prod_idx < ring_size));
endmodule

bind cq_producer cq_producer_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
  .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr),
  .mw_data(mw_data), .mw_done(mw_done), .irq_pulse(irq_pulse),
  .ring_full(ring_full), .prod_idx(prod_idx), .ring_size(ring_size)
);

// File: tb/test_cq_producer.sv
module test_cq_producer;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 64;
  localparam int IDX_W  = 16;
  localparam logic [63:0] BASE   = 64'h0000_0001_1000_0000;
  localparam logic [63:0] MIRROR = 64'h0000_0001_2000_0040;

  typedef struct {
    logic [63:0]  addr;
    logic [127:0] data;
    bit           is_idx;
  } wr_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [63:0] cfg_wdata = '0;
  logic res_valid = 1'b0;
  logic res_ready;
  logic [15:0] res_id = '0;
  logic [31:0] res_len = '0;
  logic [15:0] res_sts = '0;
  logic [63:0] res_meta = '0;
  logic mw_valid;
  logic mw_ready = 1'b0;
  logic [63:0] mw_addr;
  logic [127:0] mw_data;
  logic mw_done = 1'b0;
  logic irq_pulse;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  wr_t exp_q[$];
  int exp_prod = 0;
  int ring_sz = 0;
  bit model_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cq_producer #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_cq_producer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .res_valid(res_valid), .res_ready(res_ready),
    .res_id(res_id), .res_len(res_len), .res_sts(res_sts), .res_meta(res_meta),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr),
    .mw_data(mw_data), .mw_done(mw_done), .irq_pulse(irq_pulse)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [63:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 2'd1) begin
      ring_sz = int'(val[IDX_W-1:0]);
      exp_prod = 0;
    end
  endtask

  // Driver: pushes the expected record and index writes, then offers the result
  task automatic send(input logic [15:0] id, input logic [31:0] len,
                      input logic [15:0] sts, input logic [63:0] meta);
    wr_t w;
    int nxt;
    w.addr = BASE + 64'(exp_prod) * 64'd16;
    w.data = {meta, sts, len, id};
    w.is_idx = 1'b0;
    exp_q.push_back(w);
    nxt = (exp_prod + 1) % ring_sz;
    w.addr = MIRROR;
    w.data = 128'(nxt);
    w.is_idx = 1'b1;
    exp_q.push_back(w);
    exp_prod = nxt;
    @(negedge clk);
    res_valid = 1'b1; res_id = id; res_len = len; res_sts = sts; res_meta = meta;
    while (!res_ready) @(negedge clk);
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // Memory model and monitor: pops the scoreboard on every accepted write
  initial begin
    int cyc = 0;
    int dly = 0;
    bit outstanding = 1'b0;
    bit out_idx = 1'b0;
    bit last_done_idx = 1'b0;
    wr_t w;
    forever begin
      @(negedge clk);
      if (model_on) begin
        if (irq_pulse || last_done_idx)
          check(irq_pulse == last_done_idx, "R8", "irq vs index ack",
                128'(irq_pulse), 128'(last_done_idx));
        if (irq_pulse) irq_cnt++;
        last_done_idx = 1'b0;
        mw_done = 1'b0;
        if (outstanding) begin
          dly--;
          if (dly == 0) begin
            mw_done = 1'b1;
            outstanding = 1'b0;
            last_done_idx = out_idx;
          end
        end
        mw_ready = ((cyc % 3) != 2);
        cyc++;
        if (mw_valid && mw_ready) begin
          check(!outstanding, "R4", "request before previous ack", 128'(outstanding), 128'(0));
          if (exp_q.size() == 0) begin
            check(1'b0, "R6", "unexpected memory write", mw_addr, 128'(0));
          end else begin
            w = exp_q.pop_front();
            check(mw_addr == w.addr, w.is_idx ? "R4" : "R3", "write address", mw_addr, w.addr);
            check(mw_data == w.data, w.is_idx ? "R5" : "R3", "write data", mw_data, w.data);
          end
          outstanding = 1'b1;
          out_idx = (exp_q.size() % 2) == 0;
          dly = 2;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(mw_valid == 1'b0, "R1", "mw_valid after reset", 128'(mw_valid), 128'(0));
    check(irq_pulse == 1'b0, "R1", "irq after reset", 128'(irq_pulse), 128'(0));
    check(res_ready == 1'b0, "R1", "ready with size 0", 128'(res_ready), 128'(0));
    model_on = 1'b1;

    cfg_write(2'd0, BASE);
    cfg_write(2'd2, MIRROR);
    cfg_write(2'd1, 64'd4);
    @(negedge clk);
    check(res_ready == 1'b1, "R2", "ready after setup", 128'(res_ready), 128'(1));

    send(16'h00A1, 32'd64,   16'h0000, 64'h1111_2222_3333_4444);
    send(16'h00B2, 32'd1500, 16'h0003, 64'hDEAD_BEEF_0000_0001);
    send(16'hFFFF, 32'hFFFF_FFFF, 16'h8001, 64'h0);
    drain();
    check(irq_cnt == 3, "R8", "irq count after three", 128'(irq_cnt), 128'(3));
    check(res_ready == 1'b0, "R6", "ready while full", 128'(res_ready), 128'(1'b0));

    @(negedge clk);
    res_valid = 1'b1; res_id = 16'h0BAD;
    repeat (8) @(negedge clk);
    check(mw_valid == 1'b0 && exp_q.size() == 0, "R6", "no write while full",
          128'(mw_valid), 128'(0));
    res_valid = 1'b0;

    cfg_write(2'd3, 64'd2);
    @(negedge clk);
    check(res_ready == 1'b1, "R7", "ready after slots freed", 128'(res_ready), 128'(1));

    send(16'h0C03, 32'd8,  16'h0001, 64'hA5A5_A5A5_A5A5_A5A5);
    send(16'h0D04, 32'd16, 16'h0002, 64'h5A5A_5A5A_5A5A_5A5A);
    drain();
    check(exp_prod == 1, "R5", "bench wrap tracking", 128'(exp_prod), 128'(1));
    check(res_ready == 1'b0, "R6", "full after wrap", 128'(res_ready), 128'(0));

    cfg_write(2'd1, 64'd8);
    @(negedge clk);
    check(res_ready == 1'b1, "R2", "ready after size rewrite", 128'(res_ready), 128'(1));
    send(16'h0E05, 32'd4, 16'h0000, 64'h0123_4567_89AB_CDEF);
    send(16'h0F06, 32'd2, 16'h00FF, 64'hFEDC_BA98_7654_3210);
    drain();
    check(irq_cnt == 7, "R8", "irq count total", 128'(irq_cnt), 128'(7));
    check(exp_q.size() == 0, "R9", "scoreboard drained", 128'(exp_q.size()), 128'(0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule